// File: doc/BRIEF.md
# Root Barrier Controller with Exponential Backoff

This block runs the root side of a hardware barrier. Each group member records the current barrier sequence number locally when it reaches the barrier. After a start request, the controller sends one broadcast probe packet that carries its own sequence number. The network checks that number against the value stored at every member. The replies are merged in the network, with the worst reply winning. The controller sees the result as one combined acknowledgement.

When the combined acknowledgement says every member is ready, the controller sends a wake packet that releases the group. It then pulses `done_o` and advances its sequence number. When any member is not ready, or the network reports an error, the controller waits out a backoff interval and probes again. The interval doubles after each failed probe, is capped at a maximum, and returns to its start value once a barrier completes. Too many consecutive failures within one barrier raise a sticky error flag, and the controller keeps retrying.

Packets leave on a valid/ready stream. `pkt_valid_o` rises with a packet and stays high, with `pkt_wake_o` and `pkt_seq_o` unchanged, until the cycle in which `pkt_ready_i` is high. That cycle is the transfer. The sender may hold `pkt_ready_i` low for any number of cycles. Only one barrier runs at a time.

Top module: `barrier_root_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pkt_valid_o`, `done_o` and `err_o` are 0 and `seq_o` is 0.
- R2: A start sampled while idle makes `pkt_valid_o` high in the following cycle, with `pkt_wake_o`=0 (probe) and `pkt_seq_o` equal to `seq_o`.
- R3: While `pkt_valid_o` is high and `pkt_ready_i` is low, the packet stays offered with `pkt_wake_o` and `pkt_seq_o` unchanged. After a transfer, `pkt_valid_o` is low in the next cycle.
- R4: An acknowledgement with `ack_code_i`=0 (all members ready), sampled while awaiting one, makes the next cycle offer a wake packet (`pkt_wake_o`=1) with the same sequence number.
- R5: The cycle after the wake packet transfers, `done_o` is high for exactly one cycle. `seq_o` is one higher (modulo 2^SEQ_W) in the cycle after that and changes at no other time.
- R6: An acknowledgement with `ack_code_i`=1 (some member not ready), 2 or 3 (network error) is followed by exactly B cycles with `pkt_valid_o` low, and then a new probe. B is BO_MIN (16) after the first failure of a barrier, doubles after each further failure, and saturates at BO_MAX (4096).
- R7: `err_o` rises in the cycle after the MAX_RETRY-th (default 6) consecutive failed probe of one barrier and stays high until reset. The failure count restarts when a barrier completes.
- R8: A start sampled while a barrier is in progress is kept. The next probe then appears two cycles after the `done_o` cycle, with no new start.
- R9: `ack_valid_i` is ignored whenever no acknowledgement is awaited (idle, probe offered, backoff, wake offered).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Barrier start request |
| pkt_valid_o | output | 1 | Packet offered to the network sender |
| pkt_ready_i | input | 1 | Network sender accepts the packet |
| pkt_wake_o | output | 1 | 0 = probe packet, 1 = wake packet |
| pkt_seq_o | output | SEQ_W | Sequence number carried by the packet |
| ack_valid_i | input | 1 | Combined acknowledgement present |
| ack_code_i | input | 2 | 0 all ready, 1 not ready, 2 or 3 error |
| done_o | output | 1 | One-cycle pulse when a barrier completes |
| seq_o | output | SEQ_W | Current barrier sequence number |
| err_o | output | 1 | Sticky retry-limit error |

## Verification
A start, an accepted acknowledgement or a wake transfer each shows at the outputs one cycle after the edge that samples it. The step in `seq_o` comes one cycle later still. A failed probe keeps `pkt_valid_o` low for exactly the backoff length before the next probe. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares every output on the following falling edge, so each result is checked in the exact cycle it is due. Directed checks count the low cycles after each failed acknowledgement against the expected doubling series. They also place the pending-start probe exactly two cycles after `done_o`.

// File: rtl/barrier_root_pkg.sv
package barrier_root_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_WAIT,
    ST_BACKOFF,
    ST_RELEASE,
    ST_DONE
  } brc_state_e;

  localparam logic [1:0] ACK_ALL_READY = 2'd0;
  localparam logic       PKT_KIND_PROBE = 1'b0;
  localparam logic       PKT_KIND_WAKE  = 1'b1;

endpackage

// File: rtl/brc_backoff.sv
module brc_backoff #(
  parameter int BO_MIN = 16,
  parameter int BO_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(BO_MAX + 1);
  localparam logic [CW-1:0] MINV = CW'(BO_MIN);
  localparam logic [CW-1:0] MAXV = CW'(BO_MAX);
  localparam logic [CW-1:0] HALF = CW'(BO_MAX / 2);

  logic [CW-1:0] cur_q;
  logic [CW-1:0] cnt_q;

  generate
    if (BO_MIN >= BO_MAX) begin : g_fixed
      assign cur_q = MAXV;
    end else begin : g_grow
      logic [CW-1:0] grow_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
          grow_q <= MINV;
        end else if (load_i) begin
          grow_q <= (grow_q >= HALF) ? MAXV : {grow_q[CW-2:0], 1'b0};
        end
      end
      assign cur_q = grow_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= cur_q;
    end else if (run_i && cnt_q > CW'(1)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expire_o = (cnt_q == CW'(1));

endmodule

// File: rtl/brc_retry.sv
module brc_retry #(
  parameter int MAX_RETRY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic clear_i,
  output logic err_o
);
  localparam int CW = $clog2(MAX_RETRY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

  logic [CW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (clear_i) begin
        cnt_q <= '0;
      end else if (fail_i && cnt_q != LIMIT) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (fail_i && (cnt_q + CW'(1) >= LIMIT)) begin
        err_q <= 1'b1;
      end
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/barrier_root_ctrl.sv
module barrier_root_ctrl
  import barrier_root_pkg::*;
#(
  parameter int SEQ_W     = 8,
  parameter int BO_MIN    = 16,
  parameter int BO_MAX    = 4096,
  parameter int MAX_RETRY = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic             pkt_wake_o,
  output logic [SEQ_W-1:0] pkt_seq_o,
  input  logic             ack_valid_i,
  input  logic [1:0]       ack_code_i,
  output logic             done_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             err_o
);
  brc_state_e       st_q, st_d;
  logic             pend_q;
  logic [SEQ_W-1:0] seq_q;
  logic             fail_w;
  logic             win_w;
  logic             expire_w;

  assign fail_w = (st_q == ST_WAIT) && ack_valid_i && (ack_code_i != ACK_ALL_READY);
  assign win_w  = (st_q == ST_RELEASE) && pkt_ready_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (start_i || pend_q) st_d = ST_PROBE;
      ST_PROBE:   if (pkt_ready_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (ack_valid_i) st_d = (ack_code_i == ACK_ALL_READY) ? ST_RELEASE : ST_BACKOFF;
      end
      ST_BACKOFF: if (expire_w) st_d = ST_PROBE;
      ST_RELEASE: if (pkt_ready_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      seq_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        pend_q <= 1'b0;
      end else if (start_i) begin
        pend_q <= 1'b1;
      end
      if (st_q == ST_DONE) begin
        seq_q <= seq_q + SEQ_W'(1);
      end
    end
  end

  brc_backoff #(
    .BO_MIN (BO_MIN),
    .BO_MAX (BO_MAX)
  ) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (fail_w),
    .clear_i  (win_w),
    .run_i    (st_q == ST_BACKOFF),
    .expire_o (expire_w)
  );

  brc_retry #(
    .MAX_RETRY (MAX_RETRY)
  ) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail_i  (fail_w),
    .clear_i (win_w),
    .err_o   (err_o)
  );

  assign pkt_valid_o = (st_q == ST_PROBE) || (st_q == ST_RELEASE);
  assign pkt_wake_o  = (st_q == ST_RELEASE) ? PKT_KIND_WAKE : PKT_KIND_PROBE;
  assign pkt_seq_o   = seq_q;
  assign seq_o       = seq_q;
  assign done_o      = (st_q == ST_DONE);

endmodule

// File: rtl/barrier_root_chk.sv
module barrier_root_chk #(
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid_o,
  input logic             pkt_ready_i,
  input logic             pkt_wake_o,
  input logic [SEQ_W-1:0] pkt_seq_o,
  input logic             ack_valid_i,
  input logic [1:0]       ack_code_i,
  input logic             done_o,
  input logic [SEQ_W-1:0] seq_o,
  input logic             err_o
);

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_wake_o) && $stable(pkt_seq_o)); // R3

  AST_PKT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> pkt_seq_o == seq_o); // R2

  AST_WAKE_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid_o) && pkt_wake_o |-> $past(ack_valid_i) && $past(ack_code_i) == 2'd0); // R4

  AST_DONE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pkt_valid_o && pkt_ready_i && pkt_wake_o)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> seq_o == $past(seq_o) + 1'b1); // R5

  AST_SEQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(seq_o)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R7

endmodule

bind barrier_root_ctrl barrier_root_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_wake_o  (pkt_wake_o),
  .pkt_seq_o   (pkt_seq_o),
  .ack_valid_i (ack_valid_i),
  .ack_code_i  (ack_code_i),
  .done_o      (done_o),
  .seq_o       (seq_o),
  .err_o       (err_o)
);

// File: tb/test_barrier_root_ctrl.sv
`timescale 1ns/1ps
module test_barrier_root_ctrl;
  localparam int SEQ_W = 8;
  localparam int BMIN  = 16;
  localparam int BMAX  = 4096;
  localparam int MAXR  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             pkt_ready_i = 1'b0;
  logic             ack_valid_i = 1'b0;
  logic [1:0]       ack_code_i = 2'd0;
  logic             pkt_valid_o, pkt_wake_o, done_o, err_o;
  logic [SEQ_W-1:0] pkt_seq_o, seq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  barrier_root_ctrl #(.SEQ_W(SEQ_W), .BO_MIN(BMIN), .BO_MAX(BMAX), .MAX_RETRY(MAXR)) i_barrier_root_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i), .pkt_wake_o(pkt_wake_o),
    .pkt_seq_o(pkt_seq_o), .ack_valid_i(ack_valid_i), .ack_code_i(ack_code_i),
    .done_o(done_o), .seq_o(seq_o), .err_o(err_o)
  );

  // behavioural reference: 0 idle 1 probe 2 await 3 backoff 4 wake 5 done
  int m_st = 0, m_seq = 0, m_bo = BMIN, m_cnt = 0, m_fails = 0, m_err = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_seq = 0; m_bo = BMIN; m_cnt = 0; m_fails = 0; m_err = 0; m_pend = 0;
    end else begin
      int nxt;
      nxt = m_st;
      if (m_st != 0 && start_i) m_pend = 1;
      case (m_st)
        0: if (start_i || m_pend) begin nxt = 1; m_pend = 0; end
        1: if (pkt_ready_i) nxt = 2;
        2: if (ack_valid_i) begin
             if (ack_code_i == 2'd0) nxt = 4;
             else begin
               m_cnt = m_bo;
               m_bo = (m_bo * 2 > BMAX) ? BMAX : m_bo * 2;
               m_fails++;
               if (m_fails >= MAXR) m_err = 1;
               nxt = 3;
             end
           end
        3: if (m_cnt == 1) nxt = 1; else m_cnt--;
        4: if (pkt_ready_i) begin nxt = 5; m_bo = BMIN; m_fails = 0; end
        default: begin m_seq = (m_seq + 1) % (1 << SEQ_W); nxt = 0; end
      endcase
      m_st = nxt;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      int ev;
      ev = (m_st == 1 || m_st == 4) ? 1 : 0;
      check(pkt_valid_o == ev, "R2 R4 pkt_valid_o", pkt_valid_o, ev);
      if (ev == 1) check(pkt_wake_o == (m_st == 4), "R4 pkt_wake_o", pkt_wake_o, m_st == 4);
      check(done_o == (m_st == 5), "R5 done_o", done_o, m_st == 5);
      check(int'(seq_o) == m_seq, "R5 seq_o", seq_o, m_seq);
      check(int'(err_o) == m_err, "R7 err_o", err_o, m_err);
    end
  end

  task automatic wait_valid();
    int n = 0;
    while (!pkt_valid_o && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic run_barrier(input int nfail, input logic [1:0] fcode,
                             input bit extra_start, input bit skip_start);
    int exp_gap = BMIN;
    int seq0 = seq_o;
    if (!skip_start) begin
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      check(pkt_valid_o && !pkt_wake_o, "R2 probe after start", pkt_valid_o, 1);
      check(int'(pkt_seq_o) == seq0, "R2 probe seq", pkt_seq_o, seq0);
    end
    for (int i = 0; i <= nfail; i++) begin
      wait_valid();
      check(!pkt_wake_o, "R2 probe kind", pkt_wake_o, 0);
      ack_valid_i = 1'b1; ack_code_i = 2'd0;           // stray ack while probe offered, R9
      if (extra_start && i == 0) start_i = 1'b1;       // start while busy, R8
      @(negedge clk);
      ack_valid_i = 1'b0; start_i = 1'b0;
      check(pkt_valid_o && !pkt_wake_o, "R9 stray ack ignored", pkt_wake_o, 0);
      @(negedge clk);
      check(pkt_valid_o && int'(pkt_seq_o) == seq0, "R3 packet held", pkt_seq_o, seq0);
      pkt_ready_i = 1'b1; @(negedge clk); pkt_ready_i = 1'b0;
      check(!pkt_valid_o, "R3 valid drops after transfer", pkt_valid_o, 0);
      repeat (2) @(negedge clk);
      ack_valid_i = 1'b1;
      ack_code_i = (i < nfail) ? fcode : 2'd0;
      @(negedge clk);
      ack_valid_i = 1'b0;
      if (i < nfail) begin
        int gap = 0;
        while (!pkt_valid_o && gap < 10000) begin gap++; @(negedge clk); end
        check(gap == exp_gap, "R6 backoff length", gap, exp_gap);
        exp_gap = (exp_gap * 2 > BMAX) ? BMAX : exp_gap * 2;
      end
    end
    check(pkt_valid_o && pkt_wake_o, "R4 wake offered", pkt_wake_o, 1);
    check(int'(pkt_seq_o) == seq0, "R4 wake seq", pkt_seq_o, seq0);
    pkt_ready_i = 1'b1; @(negedge clk); pkt_ready_i = 1'b0;
    check(done_o == 1'b1, "R5 done pulse", done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", done_o, 0);
    check(int'(seq_o) == (seq0 + 1) % (1 << SEQ_W), "R5 seq step", seq_o, seq0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pkt_valid_o && !done_o && !err_o && seq_o == '0, "R1 reset state", pkt_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pkt_valid_o && !done_o && !err_o && seq_o == '0, "R1 after reset", seq_o, 0);
    ack_valid_i = 1'b1; @(negedge clk); ack_valid_i = 1'b0;
    check(!pkt_valid_o, "R9 ack ignored while idle", pkt_valid_o, 0);
    run_barrier(0, 2'd1, 0, 0);
    run_barrier(2, 2'd1, 0, 0);
    run_barrier(1, 2'd2, 0, 0);
    run_barrier(0, 2'd1, 1, 0);
    @(negedge clk);
    check(pkt_valid_o && !pkt_wake_o, "R8 pending start probe", pkt_valid_o, 1);
    run_barrier(0, 2'd1, 0, 1);
    run_barrier(3, 2'd3, 0, 0);
    check(err_o == 1'b0, "R7 below limit", err_o, 0);
    run_barrier(11, 2'd2, 0, 0);
    check(err_o == 1'b1, "R7 limit reached", err_o, 1);
    run_barrier(0, 2'd1, 0, 0);
    check(err_o == 1'b1, "R7 sticky", err_o, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule